// File: doc/BRIEF.md
# Flow Bind Throttle

This block decides whether a packet's flow hash may start an attempt to bind the flow into the forwarding table. Each hash bucket keeps a 16-bit time stamp that records when the bucket was last allowed through. A strobe input drives a free-running 16-bit tick counter. When a hash arrives, the block subtracts the bucket's stamp from the current count, modulo 2^16. If fewer ticks have passed than one tenth of the tick rate, the hash is dropped and the stamp is left alone. If enough time has passed, the stamp is moved to the current count and the block asks the table for the entry's state.

The table answers on a request/acknowledge handshake. The answer carries a success flag and a 2-bit state code. If the read fails, the attempt is abandoned. If the entry is already bound, it is skipped. Otherwise the block pulses an insert request for that bucket. Matching the flow and writing the table belong to the logic that receives that pulse.

Hashes are taken one at a time. The ready output falls from the cycle after acceptance until the controller is idle again.

The controller has four states:
- IDLE: the block waits for a hash.
- LOOKUP: the block compares the elapsed time against the threshold.
- FETCH: the block holds the entry read request.
- ISSUE: the block drives the one-cycle insert pulse.

The transitions are:
- accept: IDLE to LOOKUP, on an in-range hash.
- throttle: LOOKUP to IDLE, when too little time has passed.
- due: LOOKUP to FETCH, when enough time has passed.
- abort: FETCH to IDLE, on an acknowledge that reports a failed read.
- skip: FETCH to IDLE, on an acknowledge that reports a bound entry.
- grant: FETCH to ISSUE, on any other acknowledge.
- done: ISSUE to IDLE.

Top module: `flow_bind_throttle`

## Requirements
- R1: After reset, `hash_ready` is 1, `ent_rd_req` and `ins_req` are 0, and the tick counter and every bucket stamp are 0. As a result, a hash presented before THR ticks have elapsed is dropped.
- R2: The tick counter is 16 bits wide. It advances by one in every cycle in which `tick_i` is 1, and it wraps from 65535 to 0.
- R3: A hash whose value is above NUM_BUCKETS-1 is ignored. It raises no read request, `hash_ready` stays 1, and no bucket stamp changes.
- R4: The elapsed time is (count − stamp) mod 2^16. The threshold THR is TICKS_PER_SEC/10. If the elapsed time is below THR, the hash is dropped: no read request is raised and the stamp stays unchanged.
- R5: If the elapsed time is THR or more, the bucket's stamp becomes the latched count, and `ent_rd_req` is raised with `ent_rd_idx` equal to the hash.
- R6: `ent_rd_req` stays high until `ent_rd_ack`. An acknowledge with `ent_rd_ok` = 0 abandons the attempt, and no insert follows.
- R7: An acknowledge with `ent_rd_ok` = 1 and `ent_rd_state` = 2'b10 (bound) raises no insert. Any other state code produces a one-cycle `ins_req` pulse with `ins_idx` equal to the hash.
- R8: `hash_ready` is 0 from the cycle after acceptance until the controller is back in IDLE. The count used is the counter value in the acceptance cycle, before any increment from a `tick_i` in that same cycle.
- R9: The elapsed time is computed correctly across a counter wrap. A stamp of 65533 with a count of 6 gives 9 (dropped when THR = 10), and with a count of 9 gives 12 (issued).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Tick strobe that advances the time counter |
| hash_valid | input | 1 | A hash is presented |
| hash_in | input | HASH_W | Flow hash value |
| hash_ready | output | 1 | The block can accept a hash |
| ent_rd_req | output | 1 | Entry state read request |
| ent_rd_idx | output | IDX_W | Bucket to read |
| ent_rd_ack | input | 1 | Read answer is valid |
| ent_rd_ok | input | 1 | The read succeeded |
| ent_rd_state | input | 2 | Entry state code (2'b10 = bound) |
| ins_req | output | 1 | One-cycle insert attempt pulse |
| ins_idx | output | IDX_W | Bucket for the insert attempt |

## Verification
A tick strobe and the acceptance of a hash can fall in the same cycle. Which count then becomes the reference decides whether a bucket that sits exactly one tick short of the threshold passes or not. The bench provokes this by driving `tick_i` together with `hash_valid` when the elapsed time is THR−1, and expects a drop; it then offers the same bucket again without a tick and expects a grant. The expected outcome of each offer comes from an arithmetic model of the counter and the per-bucket stamps. That model is also swept across the 16-bit wrap.

// File: rtl/flow_bind_pkg.sv
package flow_bind_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_LOOKUP = 2'd1,
        ST_FETCH  = 2'd2,
        ST_ISSUE  = 2'd3
    } fbt_state_e;

    localparam int STAMP_W = 16;

    // Entry state code that marks an already bound entry
    localparam logic [1:0] ENT_BOUND = 2'b10;

endpackage

// File: rtl/fbt_tick_ctr.sv
module fbt_tick_ctr
    import flow_bind_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick_i,
    output logic [STAMP_W-1:0] count_o
);

    logic [STAMP_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (tick_i) begin
            cnt_q <= cnt_q + STAMP_W'(1);
        end
    end

    assign count_o = cnt_q;

    // R2
    tick_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick_i |=> (count_o == $past(count_o) + STAMP_W'(1)));

    // R2
    tick_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_i |=> $stable(count_o));

endmodule

// File: rtl/fbt_stamp_store.sv
module fbt_stamp_store
    import flow_bind_pkg::*;
#(
    parameter int DEPTH = 256,
    parameter int IDX_W = $clog2(DEPTH)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [IDX_W-1:0]   rd_idx,
    output logic [STAMP_W-1:0] rd_stamp,
    input  logic               wr_en,
    input  logic [IDX_W-1:0]   wr_idx,
    input  logic [STAMP_W-1:0] wr_stamp
);

    logic [STAMP_W-1:0] mem [DEPTH];

    generate
        for (genvar g = 0; g < DEPTH; g++) begin : g_slot
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    mem[g] <= '0;
                end else if (wr_en && (wr_idx == IDX_W'(g))) begin
                    mem[g] <= wr_stamp;
                end
            end
        end
    endgenerate

    assign rd_stamp = mem[rd_idx];

endmodule

// File: rtl/fbt_age_cmp.sv
module fbt_age_cmp
    import flow_bind_pkg::*;
#(
    parameter int THR = 100
) (
    input  logic [STAMP_W-1:0] now_i,
    input  logic [STAMP_W-1:0] stamp_i,
    output logic               due_o
);

    logic [STAMP_W-1:0] elapsed;

    always_comb begin
        elapsed = now_i - stamp_i;
        due_o   = (elapsed >= STAMP_W'(THR));
    end

endmodule

// File: rtl/flow_bind_throttle.sv
module flow_bind_throttle
    import flow_bind_pkg::*;
#(
    parameter int NUM_BUCKETS   = 256,
    parameter int HASH_W        = 16,
    parameter int TICKS_PER_SEC = 1000,
    parameter int IDX_W         = $clog2(NUM_BUCKETS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              hash_valid,
    input  logic [HASH_W-1:0] hash_in,
    output logic              hash_ready,
    output logic              ent_rd_req,
    output logic [IDX_W-1:0]  ent_rd_idx,
    input  logic              ent_rd_ack,
    input  logic              ent_rd_ok,
    input  logic [1:0]        ent_rd_state,
    output logic              ins_req,
    output logic [IDX_W-1:0]  ins_idx
);

    localparam int              THR       = TICKS_PER_SEC / 10;
    localparam logic [HASH_W-1:0] HASH_MASK = HASH_W'(NUM_BUCKETS - 1);

    fbt_state_e state_q, state_d;

    logic [STAMP_W-1:0] now_cnt;
    logic [STAMP_W-1:0] now_q;
    logic [IDX_W-1:0]   idx_q;
    logic [STAMP_W-1:0] bucket_stamp;
    logic               due;
    logic               in_range;
    logic               accept;
    logic               stamp_wr;

    assign in_range = (hash_in <= HASH_MASK);
    assign accept   = hash_valid && hash_ready && in_range;
    assign stamp_wr = (state_q == ST_LOOKUP) && due;

    fbt_tick_ctr u_tick (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_i  (tick_i),
        .count_o (now_cnt)
    );

    fbt_stamp_store #(
        .DEPTH (NUM_BUCKETS),
        .IDX_W (IDX_W)
    ) u_stamps (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_idx   (idx_q),
        .rd_stamp (bucket_stamp),
        .wr_en    (stamp_wr),
        .wr_idx   (idx_q),
        .wr_stamp (now_q)
    );

    fbt_age_cmp #(
        .THR (THR)
    ) u_age (
        .now_i   (now_q),
        .stamp_i (bucket_stamp),
        .due_o   (due)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Request capture: bucket index and count of the acceptance cycle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q <= '0;
            now_q <= '0;
        end else if (accept) begin
            idx_q <= hash_in[IDX_W-1:0];
            now_q <= now_cnt;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (accept) begin
                    state_d = ST_LOOKUP;
                end
            end
            ST_LOOKUP: begin
                state_d = due ? ST_FETCH : ST_IDLE;
            end
            ST_FETCH: begin
                if (ent_rd_ack) begin
                    if (ent_rd_ok && (ent_rd_state != ENT_BOUND)) begin
                        state_d = ST_ISSUE;
                    end else begin
                        state_d = ST_IDLE;
                    end
                end
            end
            ST_ISSUE: begin
                state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        hash_ready = 1'b0;
        ent_rd_req = 1'b0;
        ins_req    = 1'b0;
        unique case (state_q)
            ST_IDLE:   hash_ready = 1'b1;
            ST_LOOKUP: ;
            ST_FETCH:  ent_rd_req = 1'b1;
            ST_ISSUE:  ins_req    = 1'b1;
            default:   ;
        endcase
        ent_rd_idx = idx_q;
        ins_idx    = idx_q;
    end

    // R8
    busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hash_valid && hash_ready && (hash_in <= HASH_MASK)) |=> !hash_ready);

    // R3
    oor_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hash_valid && hash_ready && (hash_in > HASH_MASK)) |=> hash_ready);

    // R6
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ent_rd_req && !ent_rd_ack) |=> ent_rd_req);

    // R7
    ins_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ins_req) |-> $past(ent_rd_req && ent_rd_ack && ent_rd_ok
                                 && (ent_rd_state != ENT_BOUND)));

    // R7
    ins_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ins_req |=> !ins_req);

    // R8
    one_job_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({hash_ready, ent_rd_req, ins_req}));

endmodule

// File: tb/flow_bind_throttle_bench.sv
`timescale 1ns/1ps
module flow_bind_throttle_bench;

    localparam int NB  = 16;
    localparam int TPS = 100;
    localparam int THR = TPS / 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_i = 1'b0;
    logic        hash_valid = 1'b0;
    logic [15:0] hash_in = '0;
    logic        hash_ready;
    logic        ent_rd_req;
    logic [3:0]  ent_rd_idx;
    logic        ent_rd_ack = 1'b0;
    logic        ent_rd_ok = 1'b0;
    logic [1:0]  ent_rd_state = 2'b00;
    logic        ins_req;
    logic [3:0]  ins_idx;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    logic [15:0] now_m = '0;
    logic [15:0] stm [NB];

    always #2 clk = ~clk;

    flow_bind_throttle #(
        .NUM_BUCKETS   (NB),
        .HASH_W        (16),
        .TICKS_PER_SEC (TPS)
    ) u_flow_bind_throttle (
        .clk          (clk),
        .rst_n        (rst_n),
        .tick_i       (tick_i),
        .hash_valid   (hash_valid),
        .hash_in      (hash_in),
        .hash_ready   (hash_ready),
        .ent_rd_req   (ent_rd_req),
        .ent_rd_idx   (ent_rd_idx),
        .ent_rd_ack   (ent_rd_ack),
        .ent_rd_ok    (ent_rd_ok),
        .ent_rd_state (ent_rd_state),
        .ins_req      (ins_req),
        .ins_idx      (ins_idx)
    );

    task automatic check(input bit cond, input string req, input int act, input int exp);
        checks++;
        if (!cond) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic ticks(input int n);
        tick_i = 1'b1;
        repeat (n) @(negedge clk);
        tick_i = 1'b0;
        now_m = now_m + 16'(n);
    endtask

    // Offer one hash; starts and ends at a falling edge
    task automatic offer(input int h, input bit ok, input logic [1:0] st,
                         input bit tick_too, input string req);
        bit          inr;
        bit          fire;
        logic [15:0] el;
        int          saw_req;
        int          saw_ins;
        int          bad_idx;
        saw_req = 0;
        saw_ins = 0;
        bad_idx = 0;
        check(hash_ready == 1'b1, "R8", int'(hash_ready), 1);
        hash_valid = 1'b1;
        hash_in    = 16'(h);
        tick_i     = tick_too;
        inr  = (h < NB);
        el   = inr ? (now_m - stm[h % NB]) : 16'd0;
        fire = inr && (el >= 16'(THR));
        if (fire) stm[h] = now_m;
        if (tick_too) now_m = now_m + 16'd1;
        @(negedge clk);
        hash_valid = 1'b0;
        tick_i     = 1'b0;
        if (!inr) check(hash_ready == 1'b1, "R3", int'(hash_ready), 1);
        else      check(hash_ready == 1'b0, "R8", int'(hash_ready), 0);
        for (int k = 0; k < 8; k++) begin
            if (ent_rd_req) begin
                saw_req++;
                if (ent_rd_idx != 4'(h)) bad_idx++;
                ent_rd_ack   = 1'b1;
                ent_rd_ok    = ok;
                ent_rd_state = st;
            end else begin
                ent_rd_ack = 1'b0;
            end
            if (ins_req) begin
                saw_ins++;
                if (ins_idx != 4'(h)) bad_idx++;
            end
            @(negedge clk);
        end
        ent_rd_ack = 1'b0;
        check((saw_req != 0) == fire, req, saw_req, int'(fire));
        check(saw_req <= 1, "R6", saw_req, 1);
        check(saw_ins == int'(fire && ok && (st != 2'b10)), fire ? "R7" : req,
              saw_ins, int'(fire && ok && (st != 2'b10)));
        check(bad_idx == 0, "R5", bad_idx, 0);
        check(hash_ready == 1'b1, "R8", int'(hash_ready), 1);
    endtask

    task automatic finish_run();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc >= 190000) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 190000);
            finish_run();
        end
    end

    initial begin
        for (int i = 0; i < NB; i++) stm[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(hash_ready == 1'b1, "R1", int'(hash_ready), 1);
        check(ent_rd_req == 1'b0, "R1", int'(ent_rd_req), 0);
        check(ins_req == 1'b0, "R1", int'(ins_req), 0);

        // R1 / R4: zero stamps, zero count -> every bucket throttled
        for (int b = 0; b < NB; b++) offer(b, 1'b1, 2'b00, 1'b0, "R1");
        ticks(THR - 1);
        for (int b = 0; b < NB; b++) offer(b, 1'b1, 2'b00, 1'b0, "R4");
        ticks(1);
        // R5 / R6 / R7: all buckets due, varied read outcomes
        for (int b = 0; b < NB; b++)
            offer(b, (b % 4) != 3, 2'(b % 3), 1'b0, "R5");
        for (int b = 0; b < NB; b++) offer(b, 1'b1, 2'b01, 1'b0, "R4");

        // R3: out-of-range hashes must not alias onto bucket 0
        ticks(THR);
        offer(16, 1'b1, 2'b00, 1'b0, "R3");
        offer(32, 1'b1, 2'b00, 1'b0, "R3");
        offer(65535, 1'b1, 2'b00, 1'b0, "R3");
        offer(0, 1'b1, 2'b00, 1'b0, "R3");

        // R8: tick coincident with acceptance uses the pre-increment count
        offer(1, 1'b1, 2'b00, 1'b0, "R5");
        ticks(THR - 1);
        offer(1, 1'b1, 2'b00, 1'b1, "R8");
        offer(1, 1'b1, 2'b11, 1'b0, "R8");

        // R2 / R9: counter wrap
        ticks(int'(16'd65533 - now_m));
        offer(2, 1'b1, 2'b00, 1'b0, "R2");
        offer(4, 1'b1, 2'b00, 1'b0, "R2");
        ticks(9);
        offer(4, 1'b1, 2'b00, 1'b0, "R9");
        offer(3, 1'b1, 2'b00, 1'b0, "R9");
        ticks(3);
        offer(2, 1'b1, 2'b00, 1'b0, "R9");
        offer(4, 1'b0, 2'b00, 1'b0, "R6");

        finish_run();
    end

endmodule